// File: doc/BRIEF.md
# Wishbone Control and Status Register Bank

This block is a word-addressed register file that sits on a 32-bit classic Wishbone slave port. It holds a parameterised set of control registers and a set of status registers. Software can write and read the control registers. Their stored values drive the user logic. The user logic drives the status registers, and software can only read them.

Registers are declared as kinds. Each kind has its own repetition count, so one kind becomes a vector of identical registers at consecutive word addresses. A vector is built even when its count is 1. Per kind, a control register can have:
- a reset value;
- a mask of trigger bits, which pulse for one clock when written and always read back as zero;
- a one-cycle write strobe.

A status kind can have a one-cycle read-acknowledge pulse.

The local address space starts with a block of reserved words that map to nothing. The control elements follow in kind order, and then the status elements. With the defaults this gives the following map:

| Word address | Contents |
|---|---|
| 0, 1 | reserved |
| 2, 3, 4 | control kind 0: reset value 0x0000_0011, trigger bit 31, strobe on |
| 5 | control kind 1: reset value 0xA5A5_0000, trigger bits 3:0, no strobe |
| 6, 7 | status kind 0, read ack on |
| 8 | status kind 1, no read ack |
| 9 and up | unmapped |

Top module: `csr_bank`

## Requirements
- R1: While rst_ni is low, and immediately after reset, each control output holds its kind's reset value with the trigger bits cleared. wb_ack_o, every write strobe and every read-ack pulse are low.
- R2: When wb_cyc_i and wb_stb_i are both high and wb_ack_o is low, wb_ack_o rises on the next clock edge for one cycle. While wb_cyc_i is low, wb_stb_i alone produces no ack and no register effect.
- R3: Control element i sits at word RESERVED_WORDS+i. A write updates only the bytes whose wb_sel_i bit is set (bit b covers data bits 8b+7:8b). A read returns the stored word on wb_dat_o in the cycle wb_ack_o is high.
- R4: A write to a control element of a strobe-enabled kind raises that element's ctrl_wstb_o bit for exactly the ack cycle. Writes to kinds without a strobe, and all reads, leave the strobe low.
- R5: Trigger bits show the written value (for the selected bytes) on ctrl_o for the single ack cycle of the write and are zero afterwards. They always read back as zero on the bus.
- R6: Status element j sits at word RESERVED_WORDS+N_CTRL+j and reads return stat_i for that element. Bus writes to status words change nothing.
- R7: A read of a status element of an ack-enabled kind raises its stat_rack_o bit for exactly the ack cycle. Other status kinds and writes produce no pulse.
- R8: Reserved words (below RESERVED_WORDS) and words past the last status element read as zero. Writes to them change no control output and raise no strobe.
- R9: The elements of a vector are independent: a write to one element leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Word address |
| wb_sel_i | input | 4 | Byte enables for writes |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with wb_ack_o |
| wb_ack_o | output | 1 | Transfer acknowledge |
| ctrl_o | output | N_CTRL*32 | Control element values, element i at bits 32i+31:32i |
| ctrl_wstb_o | output | N_CTRL | One-cycle write strobe per control element |
| stat_i | input | N_STAT*32 | Status element values, element j at bits 32j+31:32j |
| stat_rack_o | output | N_STAT | One-cycle read-ack pulse per status element |

## Verification
The bench walks the address space in several ways:
- Full-word and partial-byte writes tell byte merging apart from whole-word replacement.
- Writes and reads to the strobe-enabled and plain kinds tell the strobe and ack gating apart.
- Readbacks after writes containing trigger bits show whether those bits are stored or only pulsed.

Accesses to reserved, status and unmapped words, each followed by readback of a live control word, show that ignored writes do not land elsewhere. Directed sequences then cover the reset values, a strobe held without a cycle, a request held across two edges, and a reset applied mid-run.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int MAX_KINDS = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  typedef logic [MAX_KINDS-1:0][7:0]    reps_vec_t;
  typedef logic [MAX_KINDS-1:0][DW-1:0] word_vec_t;
  typedef logic [MAX_KINDS-1:0]         flag_vec_t;

  function automatic int total_regs(input reps_vec_t r);
    int s;
    s = 0;
    for (int k = 0; k < MAX_KINDS; k++) s += int'(r[k]);
    return s;
  endfunction

  // kind that owns flat element idx (kinds laid out in ascending order)
  function automatic int kind_of(input reps_vec_t r, input int idx);
    int base;
    base = 0;
    for (int k = 0; k < MAX_KINDS; k++) begin
      if (idx < base + int'(r[k])) return k;
      base += int'(r[k]);
    end
    return 0;
  endfunction

  function automatic logic [DW-1:0] byte_mask(input logic [BW-1:0] sel);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[8*b +: 8] = {8{sel[b]}};
    return m;
  endfunction
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int ADDR_W         = 6,
  parameter int RESERVED_WORDS = 2,
  parameter int N_CTRL         = 4,
  parameter int N_STAT         = 3
) (
  input  logic [ADDR_W-1:0] adr_i,
  output logic [N_CTRL-1:0] ctrl_hit_o,
  output logic [N_STAT-1:0] stat_hit_o
);
  localparam int CTRL_BASE = RESERVED_WORDS;
  localparam int STAT_BASE = CTRL_BASE + N_CTRL;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    assign ctrl_hit_o[i] = (int'(adr_i) == CTRL_BASE + i);
  end

  for (genvar j = 0; j < N_STAT; j++) begin : g_stat
    assign stat_hit_o[j] = (int'(adr_i) == STAT_BASE + j);
  end
endmodule

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg import csr_bank_pkg::*; #(
  parameter logic [DW-1:0] DEFAULT   = '0,
  parameter logic [DW-1:0] TRIG_MASK = '0,
  parameter bit            STB_EN    = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [BW-1:0] sel_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] rd_o,
  output logic          wstb_o
);
  logic [DW-1:0] store_q, trig_q, bmask;

  assign bmask = byte_mask(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= DEFAULT & ~TRIG_MASK;
      trig_q  <= '0;
      wstb_o  <= 1'b0;
    end else begin
      trig_q <= wr_en_i ? (dat_i & bmask & TRIG_MASK) : '0;
      wstb_o <= wr_en_i & STB_EN;
      if (wr_en_i)
        store_q <= ((store_q & ~bmask) | (dat_i & bmask)) & ~TRIG_MASK;
    end
  end

  assign q_o  = store_q | trig_q;
  assign rd_o = store_q;

  assert_trig_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> ((q_o & TRIG_MASK) == '0));

  assert_hold_unwritten_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_o));
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux import csr_bank_pkg::*; #(
  parameter int N_CTRL = 4,
  parameter int N_STAT = 3
) (
  input  logic [N_CTRL*DW-1:0] ctrl_rd_i,
  input  logic [N_CTRL-1:0]    ctrl_hit_i,
  input  logic [N_STAT*DW-1:0] stat_i,
  input  logic [N_STAT-1:0]    stat_hit_i,
  output logic [DW-1:0]        rdata_o
);
  // AND-OR select; decode is one-hot so nothing overlaps, no hit -> zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CTRL; i++)
      rdata_o |= ctrl_rd_i[i*DW +: DW] & {DW{ctrl_hit_i[i]}};
    for (int j = 0; j < N_STAT; j++)
      rdata_o |= stat_i[j*DW +: DW] & {DW{stat_hit_i[j]}};
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank import csr_bank_pkg::*; #(
  parameter int        ADDR_W         = 6,
  parameter int        RESERVED_WORDS = 2,
  parameter reps_vec_t CTRL_REPS      = 64'h0000_0000_0000_0103,
  parameter word_vec_t CTRL_DEFAULT   = {{6{32'h0}}, 32'hA5A5_0000, 32'h0000_0011},
  parameter word_vec_t CTRL_TRIG      = {{6{32'h0}}, 32'h0000_000F, 32'h8000_0000},
  parameter flag_vec_t CTRL_STB_EN    = 8'b0000_0001,
  parameter reps_vec_t STAT_REPS      = 64'h0000_0000_0000_0102,
  parameter flag_vec_t STAT_ACK_EN    = 8'b0000_0001,
  localparam int       N_CTRL         = total_regs(CTRL_REPS),
  localparam int       N_STAT         = total_regs(STAT_REPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [ADDR_W-1:0]    wb_adr_i,
  input  logic [BW-1:0]        wb_sel_i,
  input  logic [DW-1:0]        wb_dat_i,
  output logic [DW-1:0]        wb_dat_o,
  output logic                 wb_ack_o,
  output logic [N_CTRL*DW-1:0] ctrl_o,
  output logic [N_CTRL-1:0]    ctrl_wstb_o,
  input  logic [N_STAT*DW-1:0] stat_i,
  output logic [N_STAT-1:0]    stat_rack_o
);
  logic                 xfer, wr, rd;
  logic [N_CTRL-1:0]    ctrl_hit;
  logic [N_STAT-1:0]    stat_hit;
  logic [N_CTRL*DW-1:0] ctrl_rd;
  logic [DW-1:0]        rdata;

  // one action per request; a held strobe is re-served every other cycle
  assign xfer = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign wr   = xfer & wb_we_i;
  assign rd   = xfer & ~wb_we_i;

  csr_addr_dec #(
    .ADDR_W(ADDR_W), .RESERVED_WORDS(RESERVED_WORDS),
    .N_CTRL(N_CTRL), .N_STAT(N_STAT)
  ) u_dec (
    .adr_i(wb_adr_i), .ctrl_hit_o(ctrl_hit), .stat_hit_o(stat_hit)
  );

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    localparam int K = kind_of(CTRL_REPS, i);
    csr_ctrl_reg #(
      .DEFAULT(CTRL_DEFAULT[K]), .TRIG_MASK(CTRL_TRIG[K]), .STB_EN(CTRL_STB_EN[K])
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr & ctrl_hit[i]),
      .sel_i  (wb_sel_i),
      .dat_i  (wb_dat_i),
      .q_o    (ctrl_o[i*DW +: DW]),
      .rd_o   (ctrl_rd[i*DW +: DW]),
      .wstb_o (ctrl_wstb_o[i])
    );
  end

  for (genvar j = 0; j < N_STAT; j++) begin : g_stat
    localparam int K = kind_of(STAT_REPS, j);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_rack_o[j] <= 1'b0;
      else         stat_rack_o[j] <= rd & stat_hit[j] & STAT_ACK_EN[K];
    end
  end

  csr_rd_mux #(.N_CTRL(N_CTRL), .N_STAT(N_STAT)) u_mux (
    .ctrl_rd_i(ctrl_rd), .ctrl_hit_i(ctrl_hit),
    .stat_i(stat_i), .stat_hit_i(stat_hit), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= xfer;
      wb_dat_o <= rd ? rdata : '0;
    end
  end

  assert_ack_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  assert_ack_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  assert_wstb_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wstb_o != '0) |-> (wb_ack_o && $past(wb_we_i) && $onehot0(ctrl_wstb_o)));

  assert_rack_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rack_o != '0) |-> (wb_ack_o && !$past(wb_we_i) && $onehot0(stat_rack_o)));

  assert_decode_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_hit, stat_hit}));
endmodule

// File: tb/csr_bank_bench.sv
module csr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 22;

  typedef struct packed {
    logic        we;
    logic [5:0]  adr;
    logic [3:0]  sel;
    logic [31:0] dat;
    logic [31:0] exp_dat;
    logic [3:0]  exp_wstb;
    logic [2:0]  exp_rack;
  } row_t;

  // state-dependent sequence; expected values follow the word map in the brief
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 6'd2, 4'hF, 32'h0,         32'h0000_0011, 4'b0000, 3'b000}, // R1 default
    '{1'b0, 6'd5, 4'hF, 32'h0,         32'hA5A5_0000, 4'b0000, 3'b000}, // R1
    '{1'b1, 6'd3, 4'hF, 32'h1234_5678, 32'h0,         4'b0010, 3'b000}, // R4
    '{1'b0, 6'd3, 4'hF, 32'h0,         32'h1234_5678, 4'b0000, 3'b000}, // R3
    '{1'b0, 6'd2, 4'hF, 32'h0,         32'h0000_0011, 4'b0000, 3'b000}, // R9
    '{1'b1, 6'd4, 4'h3, 32'hFFFF_ABCD, 32'h0,         4'b0100, 3'b000}, // R3 bytes
    '{1'b0, 6'd4, 4'hF, 32'h0,         32'h0000_ABCD, 4'b0000, 3'b000}, // R3
    '{1'b1, 6'd5, 4'hF, 32'h0000_00F3, 32'h0,         4'b0000, 3'b000}, // R4 no stb
    '{1'b0, 6'd5, 4'hF, 32'h0,         32'h0000_00F0, 4'b0000, 3'b000}, // R5 trig reads 0
    '{1'b1, 6'd2, 4'hF, 32'h8000_0022, 32'h0,         4'b0001, 3'b000}, // R4
    '{1'b0, 6'd2, 4'hF, 32'h0,         32'h0000_0022, 4'b0000, 3'b000}, // R5
    '{1'b0, 6'd6, 4'hF, 32'h0,         32'hCAFE_0006, 4'b0000, 3'b001}, // R6 R7
    '{1'b0, 6'd7, 4'hF, 32'h0,         32'hCAFE_0007, 4'b0000, 3'b010}, // R7
    '{1'b0, 6'd8, 4'hF, 32'h0,         32'hCAFE_0008, 4'b0000, 3'b000}, // R7 no ack
    '{1'b1, 6'd6, 4'hF, 32'h0,         32'h0,         4'b0000, 3'b000}, // R6 write ign
    '{1'b0, 6'd6, 4'hF, 32'h0,         32'hCAFE_0006, 4'b0000, 3'b001}, // R6
    '{1'b0, 6'd0, 4'hF, 32'h0,         32'h0,         4'b0000, 3'b000}, // R8 reserved
    '{1'b1, 6'd1, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'b0000, 3'b000}, // R8
    '{1'b1, 6'd9, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'b0000, 3'b000}, // R8 unmapped
    '{1'b0, 6'd9, 4'hF, 32'h0,         32'h0,         4'b0000, 3'b000}, // R8
    '{1'b0, 6'd63,4'hF, 32'h0,         32'h0,         4'b0000, 3'b000}, // R8
    '{1'b0, 6'd3, 4'hF, 32'h0,         32'h1234_5678, 4'b0000, 3'b000}  // R8 R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [5:0] adr = '0;
  logic [3:0] sel = '0;
  logic [31:0] wdat = '0, rdat;
  logic ack;
  logic [127:0] ctrl;
  logic [3:0] wstb;
  logic [95:0] stat = {32'hCAFE_0008, 32'hCAFE_0007, 32'hCAFE_0006};
  logic [2:0] rack;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic s_ack, a_ack;
  logic [31:0] s_dat;
  logic [3:0] s_wstb, a_wstb;
  logic [2:0] s_rack, a_rack;
  logic [127:0] s_ctrl, a_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank u_csr_bank (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .ctrl_o(ctrl), .ctrl_wstb_o(wstb), .stat_i(stat), .stat_rack_o(rack)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [5:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; wdat = d;
    @(negedge clk);
    s_ack = ack; s_dat = rdat; s_wstb = wstb; s_rack = rack; s_ctrl = ctrl;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    a_ack = ack; a_wstb = wstb; a_rack = rack; a_ctrl = ctrl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  localparam logic [127:0] DEFAULTS = {32'hA5A5_0000, 32'h11, 32'h11, 32'h11};

  initial begin
    #(CLK_PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ctrl in reset", ctrl, DEFAULTS);
    chk("R1", "ack in reset", {127'h0, ack}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pulses after reset", {121'h0, wstb, rack}, 128'h0);
    chk("R1", "ctrl after reset", ctrl, DEFAULTS);

    for (int r = 0; r < NROWS; r++) begin
      xfer(TBL[r].we, TBL[r].adr, TBL[r].sel, TBL[r].dat);
      chk("R2", $sformatf("ack row %0d", r), {127'h0, s_ack}, 128'h1);
      chk("R2", $sformatf("ack drop row %0d", r), {127'h0, a_ack}, 128'h0);
      if (!TBL[r].we)
        chk(r < 16 ? "R3/R6" : "R8", $sformatf("rdata row %0d", r), {96'h0, s_dat}, {96'h0, TBL[r].exp_dat});
      chk("R4", $sformatf("wstb row %0d", r), {124'h0, s_wstb}, {124'h0, TBL[r].exp_wstb});
      chk("R7", $sformatf("rack row %0d", r), {125'h0, s_rack}, {125'h0, TBL[r].exp_rack});
      chk("R4", $sformatf("pulses end row %0d", r), {121'h0, a_wstb, a_rack}, 128'h0);
    end

    // R5: trigger bits pulse one cycle then clear
    xfer(1'b1, 6'd5, 4'hF, 32'h0000_0005);
    chk("R5", "trig pulse elem3", {96'h0, s_ctrl[127:96]}, {96'h0, 32'h0000_0005});
    chk("R5", "trig clear elem3", {96'h0, a_ctrl[127:96]}, 128'h0);
    xfer(1'b1, 6'd2, 4'hF, 32'h8000_0033);
    chk("R5", "trig pulse elem0", {96'h0, s_ctrl[31:0]}, {96'h0, 32'h8000_0033});
    chk("R5", "trig clear elem0", {96'h0, a_ctrl[31:0]}, {96'h0, 32'h0000_0033});
    chk("R9", "neighbours kept", a_ctrl[95:32], {64'h0, 32'h0000_ABCD, 32'h1234_5678});

    // R2: strobe without cycle does nothing
    @(negedge clk);
    stb = 1'b1; we = 1'b1; adr = 6'd2; sel = 4'hF; wdat = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2", "no ack without cyc", {123'h0, ack, wstb}, 128'h0);
    end
    stb = 1'b0; we = 1'b0;
    xfer(1'b0, 6'd2, 4'hF, 32'h0);
    chk("R2", "no write without cyc", {96'h0, s_dat}, {96'h0, 32'h0000_0033});

    // R2: held request is acked once per two cycles
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'd6;
    @(negedge clk);
    chk("R2", "held ack first", {127'h0, ack}, 128'h1);
    @(negedge clk);
    chk("R2", "held ack gap", {127'h0, ack}, 128'h0);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);

    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "ctrl after mid reset", ctrl, DEFAULTS);
    rst_n = 1'b1;
    xfer(1'b0, 6'd3, 4'hF, 32'h0);
    chk("R1", "readback after mid reset", {96'h0, s_dat}, {96'h0, 32'h0000_0011});

    finish_run();
  end
endmodule